// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This unit sits beside a small processor core. It collects every interrupt request, picks one, and gives the core a branch vector with a take strobe. The request sources are:

- two reset sources: an external reset request and a watchdog timeout;
- an active-low non-maskable pin;
- a parameterised set of maskable request lines, used for external pins and peripheral events alike;
- three software requests: a vectored request that carries its own vector, a non-maskable request and a trap request.

Software loads a per-line source-enable register, a per-line mask register and a global mask bit through plain write ports.

Every source is first latched into a pending flag. When no take is outstanding, the highest-priority eligible source is registered as a take, together with its vector. The take stays up until the core acknowledges it. The acknowledge clears the pending flag of the source that was taken. A separate return-from-service pulse ends a non-maskable service, which allows the next non-maskable request through.

Top module: `intr_vector_unit`

## Requirements
- R1: A cycle with `ext_rst_req` or `wdt_rst_req` high makes `take` high with `take_vec` = 0x00 at the next clock edge. This holds even if another take is outstanding or other requests are pending.
- R2: A reset take sets `intm` to 1 and clears the enable register, the mask register and every pending request. A line that was enabled before the reset is therefore not taken afterwards, even after `intm` is cleared.
- R3: Maskable line i is taken only when all three of these hold: bit i of the enable register is 1, bit i of the mask register is 1, and `intm` is 0. A line that arrives while `intm` is 1 stays pending and is taken once `intm` is cleared.
- R4: Among eligible maskable lines the lowest index wins. Its vector is 0x02 + i. A one-cycle pulse on `line_req` gives `take` two clock edges later.
- R5: `nmi_pin_n` passes through two synchronizing flops, and only a high-to-low transition creates a request. The take appears four edges after the pin falls. A pin held low does not request again.
- R6: A non-maskable request, from the pin or from `sw_nmi_req`, is taken whatever the values of the enable register, the mask register and `intm`. Its vector is 0x24 and it sets `intm` to 1.
- R7: When several sources are pending, they are taken in this order: non-maskable, vectored software request, trap, maskable lines.
- R8: After a non-maskable take, further non-maskable requests stay pending until a `svc_return` pulse arrives. They are then taken.
- R9: A trap request gives vector 0x22 and leaves `intm` unchanged. A maskable line can be taken after the trap is acknowledged, without any write to `intm`.
- R10: A vectored software request gives the vector on `sw_int_vec` as sampled together with `sw_int_req`, and it sets `intm` to 1.
- R11: While `take` is high and `take_ack` is low, `take` and `take_vec` hold their values. `take` falls at the edge after `take_ack`. The next take rises no earlier than one edge after that, and the acknowledged source is not taken again.
- R12: After the block reset `rst_n`, `take` is 0 and `intm` is 1.
- R13: `intm_we` loads `intm_wdata` into `intm`. Taking a maskable line sets `intm` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ext_rst_req | input | 1 | External reset request |
| wdt_rst_req | input | 1 | Watchdog timeout reset request |
| nmi_pin_n | input | 1 | Asynchronous active-low non-maskable pin |
| line_req | input | N_LINE | Maskable request lines, one-cycle pulses or levels |
| sw_int_req | input | 1 | Vectored software request pulse |
| sw_int_vec | input | 6 | Vector carried by the vectored software request |
| sw_nmi_req | input | 1 | Software non-maskable request pulse |
| sw_trap_req | input | 1 | Software trap request pulse |
| en_we | input | 1 | Write strobe for the source-enable register |
| en_wdata | input | N_LINE | Data for the source-enable register |
| imr_we | input | 1 | Write strobe for the per-line mask register |
| imr_wdata | input | N_LINE | Data for the per-line mask register |
| intm_we | input | 1 | Write strobe for the global mask bit |
| intm_wdata | input | 1 | Data for the global mask bit |
| take_ack | input | 1 | Core acknowledges the current take |
| svc_return | input | 1 | Return from non-maskable service |
| take | output | 1 | Take strobe, held until acknowledged |
| take_vec | output | 6 | Branch vector of the current take |
| intm | output | 1 | Global mask bit (1 = maskable lines blocked) |

## Verification
The assertions take the following for granted about the inputs:

- `take_ack` is raised only while `take` is high.
- `svc_return` is raised only after a non-maskable service has been acknowledged.
- All request, write and reset inputs are synchronous to `clk`, except `nmi_pin_n`.

Under these conditions the take strobe, its vector and the global mask bit behave as stated.

The bench keeps to these conditions in several ways. It changes every input only on the falling clock edge. It drives each software request and line request as a single-cycle pulse. It acknowledges a take only after it has seen `take` high. It never writes `intm` in a cycle where a take is expected to start.

// File: rtl/intr_pkg.sv
// Shared types and constant vectors for the interrupt vectoring unit.
// Assumes a 6-bit vector space; line vectors start above the reset vector.
package intr_pkg;
    localparam int VEC_W = 6;
    localparam logic [VEC_W-1:0] RST_VEC  = 6'h00;
    localparam logic [VEC_W-1:0] TRAP_VEC = 6'h22;
    localparam logic [VEC_W-1:0] NMI_VEC  = 6'h24;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_RST  = 3'd1,
        SRC_NMI  = 3'd2,
        SRC_SWI  = 3'd3,
        SRC_TRAP = 3'd4,
        SRC_LINE = 3'd5
    } src_e;
endpackage

// File: rtl/nmi_edge_sync.sv
// Synchronizes the asynchronous active-low non-maskable pin with two flops
// and flags one cycle per high-to-low transition. Idles high out of reset,
// so a pin that is already low at reset release produces one request.
module nmi_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic s1_q, s2_q, prev_q;

    // Two-flop synchronizer plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= pin_n;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Falling edge of the synchronized pin.
    assign fall = prev_q & ~s2_q;

    // R5
    nmi_fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/line_pend.sv
// Pending flags for the maskable request lines. A request sets its flag,
// an acknowledge clears it, and a reset request flushes all flags.
// Assumes clear and set of the same line in one cycle keep the flag set.
module line_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    // Per-line pending storage.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) pend <= '0;
        else                 pend <= (pend & ~clr) | set;
    end
endmodule

// File: rtl/line_prio.sv
// Fixed-priority picker for eligible maskable lines: lowest index wins.
// Purely combinational; clock and reset only serve the assertion.
module line_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    // Scan from the top so the lowest eligible index is the last to assign.
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any   = 1'b1;
                idx   = IW'(i);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
    end

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (elig != '0)));
endmodule

// File: rtl/intr_vector_unit.sv
// Interrupt arbitration and vectoring unit. Latches every request source,
// arbitrates reset > non-maskable > vectored software > trap > maskable lines,
// and issues one take with its vector until the core acknowledges it.
// Assumes take_ack only while take is high; all inputs except nmi_pin_n
// are synchronous to clk.
module intr_vector_unit
    import intr_pkg::*;
#(
    parameter int               N_LINE    = 8,
    parameter logic [VEC_W-1:0] LINE_BASE = 6'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_req,
    input  logic              wdt_rst_req,
    input  logic              nmi_pin_n,
    input  logic [N_LINE-1:0] line_req,
    input  logic              sw_int_req,
    input  logic [VEC_W-1:0]  sw_int_vec,
    input  logic              sw_nmi_req,
    input  logic              sw_trap_req,
    input  logic              en_we,
    input  logic [N_LINE-1:0] en_wdata,
    input  logic              imr_we,
    input  logic [N_LINE-1:0] imr_wdata,
    input  logic              intm_we,
    input  logic              intm_wdata,
    input  logic              take_ack,
    input  logic              svc_return,
    output logic              take,
    output logic [VEC_W-1:0]  take_vec,
    output logic              intm
);
    localparam int IW = (N_LINE > 1) ? $clog2(N_LINE) : 1;

    logic              rst_any, nmi_fall, acked;
    logic              nmi_pend_q, nmi_active_q, swi_pend_q, trap_pend_q, intm_q;
    logic [VEC_W-1:0]  swi_vec_q, vec_q, sel_vec;
    logic [N_LINE-1:0] en_q, imr_q, pend, elig, grant, line_clr;
    logic [IW-1:0]     sel_idx, line_idx_q;
    logic              line_any, take_q, start;
    src_e              src_q, sel_src;

    assign rst_any = ext_rst_req | wdt_rst_req;
    assign acked   = take_q & take_ack;

    nmi_edge_sync u_nmi_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (nmi_pin_n),
        .fall  (nmi_fall)
    );

    // Clear vector for the line whose take is being acknowledged.
    always_comb begin
        line_clr = '0;
        if (acked && src_q == SRC_LINE) line_clr[line_idx_q] = 1'b1;
    end

    line_pend #(.N(N_LINE)) u_line_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rst_any),
        .set   (line_req),
        .clr   (line_clr),
        .pend  (pend)
    );

    assign elig = pend & en_q & imr_q & {N_LINE{~intm_q}};

    line_prio #(.N(N_LINE), .IW(IW)) u_line_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .any   (line_any),
        .idx   (sel_idx),
        .grant (grant)
    );

    // Source-enable and per-line mask registers, cleared by reset requests.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_any) begin
            en_q  <= '0;
            imr_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (imr_we) imr_q <= imr_wdata;
        end
    end

    // Software and non-maskable pending flags, cleared on their acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_any) begin
            nmi_pend_q  <= 1'b0;
            swi_pend_q  <= 1'b0;
            trap_pend_q <= 1'b0;
            swi_vec_q   <= '0;
        end else begin
            nmi_pend_q  <= (nmi_pend_q & ~(acked && src_q == SRC_NMI)) | nmi_fall | sw_nmi_req;
            trap_pend_q <= (trap_pend_q & ~(acked && src_q == SRC_TRAP)) | sw_trap_req;
            if (sw_int_req) begin
                swi_pend_q <= 1'b1;
                swi_vec_q  <= sw_int_vec;
            end else if (acked && src_q == SRC_SWI) begin
                swi_pend_q <= 1'b0;
            end
        end
    end

    // Fixed priority among the latched sources.
    always_comb begin
        sel_src = SRC_NONE;
        sel_vec = RST_VEC;
        if (nmi_pend_q && !nmi_active_q) begin
            sel_src = SRC_NMI;
            sel_vec = NMI_VEC;
        end else if (swi_pend_q) begin
            sel_src = SRC_SWI;
            sel_vec = swi_vec_q;
        end else if (trap_pend_q) begin
            sel_src = SRC_TRAP;
            sel_vec = TRAP_VEC;
        end else if (line_any) begin
            sel_src = SRC_LINE;
            sel_vec = LINE_BASE + VEC_W'(sel_idx);
        end
    end

    assign start = !take_q && sel_src != SRC_NONE;

    // Take strobe, vector and source record; reset requests override all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q     <= 1'b0;
            vec_q      <= RST_VEC;
            src_q      <= SRC_NONE;
            line_idx_q <= '0;
        end else if (rst_any) begin
            take_q <= 1'b1;
            vec_q  <= RST_VEC;
            src_q  <= SRC_RST;
        end else if (acked) begin
            take_q <= 1'b0;
            src_q  <= SRC_NONE;
        end else if (start) begin
            take_q     <= 1'b1;
            vec_q      <= sel_vec;
            src_q      <= sel_src;
            line_idx_q <= sel_idx;
        end
    end

    // Non-maskable service in progress, ended by a return pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_any)                nmi_active_q <= 1'b0;
        else if (start && sel_src == SRC_NMI) nmi_active_q <= 1'b1;
        else if (svc_return)                  nmi_active_q <= 1'b0;
    end

    // Global mask: set by reset and every non-trap take, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_any)                 intm_q <= 1'b1;
        else if (start && sel_src != SRC_TRAP) intm_q <= 1'b1;
        else if (intm_we)                      intm_q <= intm_wdata;
    end

    assign take     = take_q;
    assign take_vec = vec_q;
    assign intm     = intm_q;

    // R1
    reset_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_any |=> take_q && vec_q == RST_VEC && intm_q);

    // R11
    take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_q && !take_ack && !rst_any) |=> take_q && $stable(vec_q));

    // R6
    nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(take_q) && src_q == SRC_NMI) |-> vec_q == NMI_VEC && intm_q);

    // R3
    line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(take_q) && src_q == SRC_LINE) |->
            !$past(intm_q) && ((($past(en_q & imr_q)) >> line_idx_q) & N_LINE'(1)) != '0);

    // R8
    nmi_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_active_q && !svc_return && !rst_any) |=> nmi_active_q);
endmodule

// File: tb/intr_vector_unit_bench.sv
module intr_vector_unit_bench;
    localparam int N = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext_rst_req = 0, wdt_rst_req = 0, nmi_pin_n = 1;
    logic [N-1:0] line_req = '0, en_wdata = '0, imr_wdata = '0;
    logic sw_int_req = 0, sw_nmi_req = 0, sw_trap_req = 0;
    logic [5:0] sw_int_vec = '0;
    logic en_we = 0, imr_we = 0, intm_we = 0, intm_wdata = 0;
    logic take_ack = 0, svc_return = 0;
    logic take, intm;
    logic [5:0] take_vec;

    int tests = 0, fails = 0;

    intr_vector_unit #(.N_LINE(N), .LINE_BASE(6'h02)) u_intr_vector_unit (
        .clk(clk), .rst_n(rst_n), .ext_rst_req(ext_rst_req), .wdt_rst_req(wdt_rst_req),
        .nmi_pin_n(nmi_pin_n), .line_req(line_req), .sw_int_req(sw_int_req),
        .sw_int_vec(sw_int_vec), .sw_nmi_req(sw_nmi_req), .sw_trap_req(sw_trap_req),
        .en_we(en_we), .en_wdata(en_wdata), .imr_we(imr_we), .imr_wdata(imr_wdata),
        .intm_we(intm_we), .intm_wdata(intm_wdata), .take_ack(take_ack),
        .svc_return(svc_return), .take(take), .take_vec(take_vec), .intm(intm)
    );

    always #2 clk = ~clk;

    // {enable, mask, line pulse, expected vector or FF for no take}
    localparam logic [31:0] VECS [8] = '{
        {8'hFF, 8'hFF, 8'h01, 8'h02},
        {8'hFF, 8'hFF, 8'h28, 8'h05},
        {8'hFF, 8'hFF, 8'h80, 8'h09},
        {8'hF0, 8'hFF, 8'h3C, 8'h06},
        {8'hFF, 8'h0F, 8'hF0, 8'hFF},
        {8'hAA, 8'h55, 8'hFF, 8'hFF},
        {8'hFF, 8'hFF, 8'hFF, 8'h02},
        {8'h80, 8'h80, 8'hC0, 8'h09}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ack();
        take_ack = 1; step(1); take_ack = 0;
    endtask

    task automatic wait_take(input int max);
        for (int i = 0; i < max && !take; i++) step(1);
    endtask

    task automatic wr(input logic [N-1:0] e, input logic [N-1:0] m, input logic im);
        en_we = 1; imr_we = 1; intm_we = 1;
        en_wdata = e; imr_wdata = m; intm_wdata = im;
        step(1);
        en_we = 0; imr_we = 0; intm_we = 0;
    endtask

    task automatic set_intm(input logic v);
        intm_we = 1; intm_wdata = v; step(1); intm_we = 0;
    endtask

    task automatic do_reset(input bit wdt);
        if (wdt) wdt_rst_req = 1; else ext_rst_req = 1;
        step(1);
        ext_rst_req = 0; wdt_rst_req = 0;
        check(take && take_vec == 6'h00 && intm, "R1 reset take", take_vec, 0);
        ack();
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R12 block reset state
        check(take == 0 && intm == 1, "R12 reset state", {take, intm}, 2'b01);

        // R1 / R2: external reset, then clearing of enables
        wr(8'hFF, 8'hFF, 1'b0);
        do_reset(0);
        check(intm == 1, "R2 intm after reset", intm, 1);
        set_intm(0);
        line_req = 8'h01; step(1); line_req = '0;
        step(4);
        check(take == 0, "R2 enables cleared by reset", take, 0);

        // R1: watchdog reset overrides an outstanding take
        sw_trap_req = 1; step(1); sw_trap_req = 0;
        wait_take(6);
        check(take && take_vec == 6'h22, "R9 trap before reset", take_vec, 6'h22);
        wdt_rst_req = 1; step(1); wdt_rst_req = 0;
        check(take && take_vec == 6'h00, "R1 reset overrides busy", take_vec, 0);
        ack();
        step(1);
        check(take == 0, "R11 acked source not retaken", take, 0);

        // R3 / R4: vector table walk
        foreach (VECS[k]) begin
            do_reset(k % 2);
            wr(VECS[k][31:24], VECS[k][23:16], 1'b0);
            line_req = VECS[k][15:8]; step(1); line_req = '0;
            step(1);
            if (VECS[k][7:0] == 8'hFF) begin
                step(4);
                check(take == 0, "R3 masked lines not taken", take, 0);
            end else begin
                check(take && take_vec == VECS[k][5:0], "R4 lowest line vector",
                      take_vec, VECS[k][5:0]);
                ack();
            end
        end

        // R3 / R13: global mask holds a line pending; write releases it
        do_reset(0);
        wr(8'hFF, 8'hFF, 1'b1);
        line_req = 8'h02; step(1); line_req = '0;
        step(4);
        check(take == 0, "R3 global mask blocks", take, 0);
        set_intm(0);
        wait_take(4);
        check(take && take_vec == 6'h03, "R3 pending line after unmask", take_vec, 6'h03);
        check(intm == 1, "R13 line take sets intm", intm, 1);
        ack();

        // R5 / R6: pin falling edge, four-edge latency, no retrigger
        do_reset(1);
        set_intm(0);
        nmi_pin_n = 0;
        step(3);
        check(take == 0, "R5 sync latency early", take, 0);
        step(1);
        check(take && take_vec == 6'h24 && intm, "R6 pin NMI vector", take_vec, 6'h24);
        ack();
        svc_return = 1; step(1); svc_return = 0;
        step(8);
        check(take == 0, "R5 held low no retrigger", take, 0);
        nmi_pin_n = 1;
        step(4);

        // R6 / R8: software NMI and lockout
        sw_nmi_req = 1; step(1); sw_nmi_req = 0;
        step(1);
        check(take && take_vec == 6'h24, "R6 software NMI vector", take_vec, 6'h24);
        ack();
        sw_nmi_req = 1; step(1); sw_nmi_req = 0;
        step(4);
        check(take == 0, "R8 NMI locked out", take, 0);
        svc_return = 1; step(1); svc_return = 0;
        wait_take(6);
        check(take && take_vec == 6'h24, "R8 NMI after return", take_vec, 6'h24);
        ack();
        svc_return = 1; step(1); svc_return = 0;

        // R7 / R10: ordering with everything pending at once
        do_reset(0);
        wr(8'hFF, 8'hFF, 1'b0);
        line_req = 8'h01; sw_trap_req = 1; sw_int_req = 1; sw_int_vec = 6'h30; sw_nmi_req = 1;
        step(1);
        line_req = '0; sw_trap_req = 0; sw_int_req = 0; sw_nmi_req = 0;
        wait_take(6);
        check(take && take_vec == 6'h24, "R7 NMI first", take_vec, 6'h24);
        ack();
        wait_take(6);
        check(take && take_vec == 6'h30, "R7 vectored software second", take_vec, 6'h30);
        ack();
        wait_take(6);
        check(take && take_vec == 6'h22, "R7 trap third", take_vec, 6'h22);
        ack();
        step(3);
        check(take == 0, "R7 line waits for intm", take, 0);
        set_intm(0);
        wait_take(6);
        check(take && take_vec == 6'h02, "R7 line last", take_vec, 6'h02);
        ack();

        // R9: trap keeps intm clear; a line is then taken
        set_intm(0);
        sw_trap_req = 1; step(1); sw_trap_req = 0;
        wait_take(6);
        check(take && take_vec == 6'h22, "R9 trap vector", take_vec, 6'h22);
        check(intm == 0, "R9 trap leaves intm", intm, 0);
        ack();
        line_req = 8'h04; step(1); line_req = '0;
        wait_take(6);
        check(take && take_vec == 6'h04, "R9 line during trap service", take_vec, 6'h04);
        ack();

        // R10: vectored software request sets intm
        set_intm(0);
        sw_int_req = 1; sw_int_vec = 6'h11; step(1); sw_int_req = 0; sw_int_vec = 6'h3F;
        wait_take(6);
        check(take && take_vec == 6'h11, "R10 operand vector", take_vec, 6'h11);
        check(intm == 1, "R10 sets intm", intm, 1);
        ack();

        // R11: hold until acknowledge, then the waiting request
        set_intm(0);
        line_req = 8'h20; step(1); line_req = '0;
        step(1);
        check(take && take_vec == 6'h07, "R11 line 5 take", take_vec, 6'h07);
        sw_trap_req = 1; step(1); sw_trap_req = 0;
        step(2);
        check(take && take_vec == 6'h07, "R11 held without ack", take_vec, 6'h07);
        take_ack = 1; step(1); take_ack = 0;
        check(take == 0, "R11 drops after ack", take, 0);
        step(1);
        check(take && take_vec == 6'h22, "R11 next take after gap", take_vec, 6'h22);
        ack();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule